// File: doc/BRIEF.md
# Hybrid Coarse/Fine Digital Pulse-Width Modulator

This block produces a single pulse-width modulated output for switching power-converter control. One switching period is split into 256 coarse steps. Each coarse step is split again into four quarter steps, which stand in for four clock phases spaced 90 degrees apart. The fine timing comes from a fast clock that runs at four times the coarse rate, together with a 2-bit phase index, so no clock-management primitive is needed. A period therefore lasts 1024 fast clock cycles.

A 10-bit duty command sets the pulse width. The top eight bits are matched against the coarse count. The two low bits pick the quarter step in which the pulse ends. Both the start request and the end request are decoded by synchronous comparators and registered. They then drive a clocked set/reset latch that holds the output. No path resets the output asynchronously. The command is taken only at the boundary between two periods, so a pulse already in progress keeps its width.

Timing is counted in rising clock edges with `rst_n` high since reset was released. Call that count t. Period p covers edges 1024p to 1024p+1023, and its duty value D is the value of `duty_i` at edge 1024p. Period 0 always uses D = 0. The output trails the slot counter by two clock edges.

Top module: `hpwm_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, all counters, the held command and the latch are cleared, and `pwm_o` reads 0 after that edge. The first period after reset uses a duty of 0.
- R2: The period is exactly 1024 fast clock cycles. The phase index advances on every edge and the coarse count advances only when the phase wraps from 3 to 0, so successive rising edges of `pwm_o` are a non-zero multiple of 1024 cycles apart.
- R3: For a period with D not equal to 0, `pwm_o` becomes 1 after edge 1024p+2.
- R4: The end request fires in the slot where the coarse count equals D[9:2] and the phase equals D[1:0]. `pwm_o` becomes 0 after edge 1024p+D+2, so the pulse is exactly D fast cycles wide.
- R5: With D equal to 0, no start request is made, the end request wins, and `pwm_o` stays 0 for the whole period.
- R6: `duty_i` is sampled only on the last slot of a period. A change at any other time has no effect on the running period's pulse.
- R7: With D equal to 1023, `pwm_o` is 0 for exactly one fast cycle per period.
- R8: Changing only D[1:0] moves the falling edge by that many quarter steps, which is one fast cycle per count, while the rising edge stays where it is.
- R9: A reset asserted in the middle of a pulse forces `pwm_o` to 0 after the next edge. Operation then restarts with the timing of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the coarse step rate |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | 10 | Duty command: [9:2] coarse step, [1:0] quarter step |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench targets four corner cases.

- **Zero duty.** A design that let the start request through on a zero command would emit a one-slot glitch at the start of the period.
- **Full-scale duty.** A coarse comparison that ignored the phase bits, or that ended the pulse a slot too early or too late, would make the single low cycle vanish or double.
- **Every low-bit value.** Commands 4 to 7 and random values exercise all four quarter phases. A wrong phase select shifts the falling edge by whole fast cycles.
- **Mid-period command changes and resets.** The command changes in the middle of every period to catch a design that loads it early and distorts the running pulse. A reset asserted in the middle of a pulse catches a latch that keeps its state through reset.

// File: rtl/hpwm_pkg.sv
// hpwm_pkg: shared types for the hybrid PWM.
// Assumes nothing beyond being compiled before the modules that use it.
package hpwm_pkg;

    // Edge requests produced by the comparator stage.
    typedef struct packed {
        logic set;
        logic clr;
    } hpwm_req_t;

endpackage

// File: rtl/hpwm_timebase.sv
// hpwm_timebase: two-level slot counter. A PH_W-bit phase index runs on
// every fast clock edge. A CNT_W-bit coarse count steps when the phase
// wraps. Also gives a one-hot phase vector, a period-start strobe and a
// last-slot strobe.
// Assumes: synchronous active-low reset and a free-running clock.
module hpwm_timebase #(
    parameter int CNT_W = 8,
    parameter int PH_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [PH_W-1:0]            phase_o,
    output logic [CNT_W-1:0]           coarse_o,
    output logic [(1 << PH_W)-1:0]     phase_oh_o,
    output logic                       start_o,
    output logic                       wrap_o
);
    localparam int NPH = 1 << PH_W;
    localparam logic [PH_W-1:0]  PH_LAST  = {PH_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] coarse_q;

    // Phase index: steps on every fast edge and wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Coarse count: steps once per full phase rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
        end else if (phase_q == PH_LAST) begin
            coarse_q <= coarse_q + 1'b1;
        end
    end

    // One-hot phase decode, one comparator per phase.
    for (genvar g = 0; g < NPH; g++) begin : g_phase_oh
        assign phase_oh_o[g] = (phase_q == PH_W'(g));
    end

    assign phase_o  = phase_q;
    assign coarse_o = coarse_q;
    assign start_o  = (coarse_q == '0) && phase_oh_o[0];
    assign wrap_o   = (coarse_q == CNT_LAST) && phase_oh_o[NPH-1];
endmodule

// File: rtl/hpwm_duty_hold.sv
// hpwm_duty_hold: holds the duty command for the current period. Loads
// only when the last slot of a period is strobed, so the new value takes
// effect from slot zero of the next period.
// Assumes: load_i is a one-cycle strobe once per period.
module hpwm_duty_hold #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic              nonzero_o
);
    logic [DUTY_W-1:0] duty_q;

    // Command register: cleared by reset, refreshed at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (load_i) begin
            duty_q <= duty_i;
        end
    end

    assign duty_o    = duty_q;
    assign nonzero_o = |duty_q;
endmodule

// File: rtl/hpwm_edge_decode.sv
// hpwm_edge_decode: synchronous comparators for the start and end of the
// pulse. Start fires at slot zero when the command is non-zero. End fires
// when the coarse count matches the command's upper bits and the active
// phase matches its lower bits. Both requests are registered.
// Assumes: phase_oh_i is one-hot.
module hpwm_edge_decode
    import hpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PH_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            coarse_i,
    input  logic [(1 << PH_W)-1:0]      phase_oh_i,
    input  logic                        start_i,
    input  logic [CNT_W+PH_W-1:0]       duty_i,
    input  logic                        nonzero_i,
    output hpwm_req_t                   req_o
);
    localparam int NPH = 1 << PH_W;

    logic [NPH-1:0] fine_hit;
    logic           coarse_hit;
    hpwm_req_t      req_d;
    hpwm_req_t      req_q;

    // One phase-select term per quarter step.
    for (genvar g = 0; g < NPH; g++) begin : g_fine
        assign fine_hit[g] = phase_oh_i[g] && (duty_i[PH_W-1:0] == PH_W'(g));
    end

    assign coarse_hit = (coarse_i == duty_i[CNT_W+PH_W-1:PH_W]);

    // Combinational request decode for the current slot.
    always_comb begin
        req_d.set = start_i && nonzero_i;
        req_d.clr = coarse_hit && (|fine_hit);
    end

    // Request register: removes comparator glitches before the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/hpwm_sr_latch.sv
// hpwm_sr_latch: clocked set/reset hold element for the output. Clear
// wins over set, and reset forces the output low.
// Assumes: requests are registered and free of glitches.
module hpwm_sr_latch
    import hpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hpwm_req_t req_i,
    output logic      q_o
);
    logic q_q;

    // Output hold: clear first, then set, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else if (req_i.clr) begin
            q_q <= 1'b0;
        end else if (req_i.set) begin
            q_q <= 1'b1;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/hpwm_core.sv
// hpwm_core: top of the hybrid coarse/fine PWM. Wires the timebase, the
// command hold register, the edge comparators and the output latch.
// Assumes: clk runs at 2**PH_W times the coarse step rate; reset is
// synchronous and active low.
module hpwm_core
    import hpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PH_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W+PH_W-1:0]   duty_i,
    output logic                    pwm_o
);
    localparam int DUTY_W = CNT_W + PH_W;
    localparam int NPH    = 1 << PH_W;

    logic [PH_W-1:0]   phase_w;
    logic [CNT_W-1:0]  coarse_w;
    logic [NPH-1:0]    phase_oh_w;
    logic              start_w;
    logic              wrap_w;
    logic [DUTY_W-1:0] duty_q_w;
    logic              nonzero_w;
    hpwm_req_t         req_w;
    logic              set_w;
    logic              clr_w;

    hpwm_timebase #(.CNT_W(CNT_W), .PH_W(PH_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase_w),
        .coarse_o   (coarse_w),
        .phase_oh_o (phase_oh_w),
        .start_o    (start_w),
        .wrap_o     (wrap_w)
    );

    hpwm_duty_hold #(.DUTY_W(DUTY_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wrap_w),
        .duty_i    (duty_i),
        .duty_o    (duty_q_w),
        .nonzero_o (nonzero_w)
    );

    hpwm_edge_decode #(.CNT_W(CNT_W), .PH_W(PH_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .coarse_i   (coarse_w),
        .phase_oh_i (phase_oh_w),
        .start_i    (start_w),
        .duty_i     (duty_q_w),
        .nonzero_i  (nonzero_w),
        .req_o      (req_w)
    );

    hpwm_sr_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_w),
        .q_o   (pwm_o)
    );

    assign set_w = req_w.set;
    assign clr_w = req_w.clr;
endmodule

// File: rtl/hpwm_core_chk.sv
// hpwm_core_chk: property checker bound into hpwm_core. Watches the slot
// counters, the command register, the requests and the output.
module hpwm_core_chk #(
    parameter int CNT_W = 8,
    parameter int PH_W  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CNT_W+PH_W-1:0] duty_i,
    input logic [PH_W-1:0]       phase,
    input logic [CNT_W-1:0]      coarse,
    input logic [CNT_W+PH_W-1:0] duty_q,
    input logic                  wrap,
    input logic                  set_req,
    input logic                  clr_req,
    input logic                  pwm_o
);
    localparam logic [PH_W-1:0]        PH_ONE   = 1;
    localparam logic [CNT_W-1:0]       CNT_ONE  = 1;
    localparam logic [PH_W-1:0]        PH_LAST  = {PH_W{1'b1}};
    localparam logic [CNT_W+PH_W-1:0]  DUTY_MAX = {(CNT_W+PH_W){1'b1}};

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == $past(phase) + PH_ONE);

    p_coarse_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST) |=> coarse == $past(coarse) + CNT_ONE);

    p_coarse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LAST) |=> $stable(coarse));

    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));

    p_duty_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> duty_q == $past(duty_i));

    p_zero_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |=> !set_req);

    p_set_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> pwm_o);

    p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !pwm_o);

    p_max_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == DUTY_MAX && wrap) |=> clr_req);
endmodule

bind hpwm_core hpwm_core_chk #(.CNT_W(CNT_W), .PH_W(PH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_i  (duty_i),
    .phase   (phase_w),
    .coarse  (coarse_w),
    .duty_q  (duty_q_w),
    .wrap    (wrap_w),
    .set_req (set_w),
    .clr_req (clr_w),
    .pwm_o   (pwm_o)
);

// File: tb/hpwm_core_test.sv
// Bench for hpwm_core: directed corner periods plus seeded random duties,
// with a mid-period command change in every period, compared every cycle
// against a period-level reference computed in the bench.
module hpwm_core_test;
    localparam int PER = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] duty_i = '0;
    logic       pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state, updated at every rising edge.
    int t = 0;
    int d_cur = 0;
    int d_prev = 0;
    int dd = 0;
    bit exp_pwm = 1'b0;
    int last_rise = -1;
    bit prev_pwm = 1'b0;
    bit r9_zone = 1'b0;

    hpwm_core uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty_i),
        .pwm_o  (pwm_o)
    );

    always #4 clk = ~clk;

    // Reference: output at edge t reflects slot t-2.
    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            t = 0; d_cur = 0; d_prev = 0;
            exp_pwm = 1'b0; dd = 0;
        end else begin
            t = t + 1;
            if (t % PER == 0) begin
                d_prev = d_cur;
                d_cur  = int'(duty_i);
            end
            s = t - 2;
            if (s < 0) begin
                exp_pwm = 1'b0; dd = 0;
            end else begin
                dd = (s / PER == t / PER) ? d_cur : d_prev;
                exp_pwm = ((s % PER) < dd);
            end
        end
    end

    function automatic string tag_for(int tt, int d);
        int s = tt - 2;
        if (r9_zone)            return "R9";
        if (s < PER)            return "R1";
        if (d == 0)             return "R5";
        if (d == 1023)          return "R7";
        if (s % PER == 0)       return "R3";
        if (s % PER == d)       return "R4";
        if ((d % 4) != 0)       return "R8";
        return "R6";
    endfunction

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (pwm_o !== exp_pwm) begin
                n_bad++;
                $display("FAIL %s t=%0d duty=%0d pwm actual=%0b expected=%0b",
                         tag_for(t, dd), t, dd, pwm_o, exp_pwm);
            end
            if (rst_n && pwm_o && !prev_pwm) begin
                if (last_rise >= 0) begin
                    n_chk++;
                    if (((t - last_rise) % PER) != 0 || t == last_rise) begin
                        n_bad++;
                        $display("FAIL R2 rise spacing actual=%0d expected=multiple of %0d",
                                 t - last_rise, PER);
                    end
                end
                last_rise = t;
            end
            if (!rst_n) last_rise = -1;
            prev_pwm = pwm_o;
        end
    end

    // Wait until the next edge is the period boundary, then present d.
    // Later in the period, place junk on the input that must be ignored.
    task automatic run_period(input int d);
        do @(negedge clk); while (t % PER != PER - 1);
        duty_i = 10'(d);
        do @(negedge clk); while (t % PER != 300);
        duty_i = 10'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        n_chk++;
        if (pwm_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset pwm actual=%0b expected=0", pwm_o);
        end
        rst_n = 1'b1;
        run_period(1);
        run_period(4);
        run_period(5);
        run_period(6);
        run_period(7);
        run_period(0);
        run_period(1023);
        run_period(1022);
        run_period(512);
        run_period(0);
        run_period(3);
        for (int i = 0; i < 14; i++) run_period(int'($urandom_range(1, 1023)));
        // R9: reset in the middle of a pulse.
        run_period(800);
        do @(negedge clk); while (t % PER != 400);
        r9_zone = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_period(257);
        r9_zone = 1'b0;
        run_period(1023);
        run_period(2);
        do @(negedge clk); while (t % PER != PER - 10);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule